// File: doc/BRIEF.md
# Paced Multichannel Conversion Controller

This block is the control logic of an eight-channel, 12-bit data acquisition front end that sits on a simple byte-wide host bus. The host programs a function register that selects a channel, enables the pacer, and chooses how the channel is picked and how conversions start. The block counts ticks from an external pacer timer and starts one conversion on an external converter for every eighth counted tick. It uses a one-cycle start pulse and a one-cycle done pulse for this handshake. In software-trigger mode, a host write to the start address opens a window of pacer ticks. That window lasts just long enough for one conversion cycle.

Each finished result pulls an active-low ready flag down and raises a one-cycle interrupt pulse. The host reads the 12-bit value as two reads of one address: the low byte first, then the high byte, whose upper nibble is zero. The second read releases the flag. In scan mode, that same read moves the channel pointer on to the next input. The result path offers no back-pressure. A result that arrives before the previous one has been fully read replaces it, and a sticky overrun bit records the loss. Timer register writes from the host pass through to the external timer only while the pacer is enabled.

Top module: `paced_acq_ctrl`

## Requirements
- R1: A write to offset 4 loads the function register: bits [2:0] channel, bit 4 pacer enable, bit 5 scan mode, bit 6 software trigger; bits 3 and 7 have no effect.
- R2: While pacer enable is 0, pacer ticks and start-address writes cause no conversion, and host writes to offsets 0 to 3 raise no timer write strobe; with enable 1 such a write strobes the timer with the offset and data.
- R3: With scan mode 0, every conversion uses the channel held in bits [2:0] of the function register.
- R4: With pacer enable 1 and software trigger 0, exactly one conversion starts on every eighth pacer tick counted since the last function register write.
- R5: With software trigger 1, ticks are ignored until a write to offset 5; the eighth tick after that write starts one conversion and closes the window.
- R6: An eighth tick that arrives while a conversion is still in progress starts nothing.
- R7: The clock edge that captures the done pulse drives the ready flag (status bit 0, active low) to 0, and the interrupt is high for exactly the following cycle.
- R8: Reads of offset 6 return the low result byte first, then {4'b0000, result[11:8]}; a new result resets this order to the low byte.
- R9: The ready flag returns to 1 only after the high-byte read.
- R10: With scan mode 1, a function register write loads the channel pointer from bits [2:0], and each high-byte read advances it by one, wrapping from 7 to 0.
- R11: A result arriving while the ready flag is 0 replaces the held value and sets status bit 1; a read of offset 7 clears that bit.
- R12: After reset the ready flag is 1, interrupt and start are 0, and the status register reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 3 | Host register offset |
| bus_wr_i | input | 1 | Host write strobe, one cycle |
| bus_rd_i | input | 1 | Host read strobe, one cycle; side effects at its clock edge |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Read data for the current offset |
| tmr_wr_o | output | 1 | Timer register write strobe |
| tmr_sel_o | output | 2 | Timer register select |
| tmr_wdata_o | output | 8 | Timer register write data |
| pacer_run_o | output | 1 | Pacer timer run enable |
| pacer_tick_i | input | 1 | One-cycle pacer tick |
| adc_start_o | output | 1 | One-cycle conversion start |
| adc_chan_o | output | 3 | Channel for the started conversion |
| adc_done_i | input | 1 | One-cycle conversion done |
| adc_result_i | input | 12 | Conversion result, valid with done |
| drdy_n_o | output | 1 | Result ready flag, active low |
| irq_o | output | 1 | Interrupt pulse per result |

## Verification
The hardest state to reach from the ports is an eighth tick that lands while the converter is still busy. The converter model in the bench has a latency that the stimulus can change: it is stretched beyond sixteen tick-spaced cycles, and sixteen ticks are sent so that the second start is due mid-conversion. The overrun path needs two results with only a partial read between them. The stimulus reads just the low byte of the first result before forcing the second. This also shows that the byte order restarts.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_FCR   = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_START = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 3'd7;

  localparam int FCR_PEN_BIT  = 4;
  localparam int FCR_SCAN_BIT = 5;
  localparam int FCR_TRIG_BIT = 6;

  typedef enum logic {
    BYTE_LO = 1'b0,
    BYTE_HI = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/acq_hostif.sv
module acq_hostif
  import acq_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CH_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [CH_W-1:0]   ch_o,
  output logic              pen_o,
  output logic              scan_o,
  output logic              trig_o,
  output logic              fcr_wr_o,
  output logic [CH_W-1:0]   fcr_new_ch_o,
  output logic              start_wr_o,
  output logic              data_rd_o,
  output logic              stat_rd_o,
  output logic              tmr_wr_o,
  output logic [1:0]        tmr_sel_o,
  output logic [BUS_W-1:0]  tmr_wdata_o
);
  logic [CH_W-1:0] ch_q;
  logic            pen_q, scan_q, trig_q;

  assign fcr_wr_o     = wr_i && (addr_i == OFS_FCR);
  assign fcr_new_ch_o = wdata_i[CH_W-1:0];

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ch_q   <= '0;
      pen_q  <= 1'b0;
      scan_q <= 1'b0;
      trig_q <= 1'b0;
    end else if (fcr_wr_o) begin
      ch_q   <= wdata_i[CH_W-1:0];
      pen_q  <= wdata_i[FCR_PEN_BIT];
      scan_q <= wdata_i[FCR_SCAN_BIT];
      trig_q <= wdata_i[FCR_TRIG_BIT];
    end
  end

  assign ch_o   = ch_q;
  assign pen_o  = pen_q;
  assign scan_o = scan_q;
  assign trig_o = trig_q;

  // start-address writes count only while the pacer is enabled
  assign start_wr_o = wr_i && (addr_i == OFS_START) && pen_q;
  assign data_rd_o  = rd_i && (addr_i == OFS_DATA);
  assign stat_rd_o  = rd_i && (addr_i == OFS_STAT);

  // timer load path: offsets below the function register, blocked without pacer enable
  assign tmr_wr_o    = wr_i && (addr_i < OFS_FCR) && pen_q;
  assign tmr_sel_o   = addr_i[1:0];
  assign tmr_wdata_o = wdata_i;
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
  parameter int CH_W = 3,
  parameter int TPC  = 8
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            pen_i,
  input  logic            scan_i,
  input  logic            trig_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic            fcr_wr_i,
  input  logic [CH_W-1:0] fcr_new_ch_i,
  input  logic            start_wr_i,
  input  logic            tick_i,
  input  logic            hi_read_i,
  input  logic            adc_done_i,
  output logic            adc_start_o,
  output logic [CH_W-1:0] adc_chan_o
);
  localparam int CNT_W = (TPC > 1) ? $clog2(TPC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TPC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             burst_q;
  logic             busy_q;
  logic             start_q;
  logic [CH_W-1:0]  chan_q;
  logic [CH_W-1:0]  ptr_q;
  logic             tick_ok, restart, arm, fire;
  logic [CH_W-1:0]  cur_chan;

  assign restart  = fcr_wr_i || !pen_i;
  assign arm      = start_wr_i && trig_i;
  assign tick_ok  = pen_i && tick_i && (!trig_i || burst_q);
  assign fire     = tick_ok && (cnt_q == CNT_LAST) && !restart && !arm;
  assign cur_chan = scan_i ? ptr_q : ch_i;

  // tick counter and software burst window
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q   <= '0;
      burst_q <= 1'b0;
    end else if (restart) begin
      cnt_q   <= '0;
      burst_q <= 1'b0;
    end else if (arm) begin
      cnt_q   <= '0;
      burst_q <= 1'b1;
    end else if (tick_ok) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q   <= '0;
        burst_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // conversion launch and busy tracking
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      start_q <= 1'b0;
      chan_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      start_q <= fire && !busy_q;
      if (fire && !busy_q) begin
        chan_q <= cur_chan;
        busy_q <= 1'b1;
      end else if (adc_done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  // scan pointer
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ptr_q <= '0;
    end else if (fcr_wr_i) begin
      ptr_q <= fcr_new_ch_i;
    end else if (hi_read_i && scan_i) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign adc_start_o = start_q;
  assign adc_chan_o  = chan_q;

  assert_start_needs_pacer_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    start_q |-> $past(pen_i))
    else $error("start issued without pacer enable");

  assert_manual_chan_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (start_q && !$past(scan_i)) |-> (chan_q == $past(ch_i)))
    else $error("manual channel not used");

  assert_sw_needs_window_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (start_q && $past(trig_i)) |-> $past(burst_q))
    else $error("software-mode start outside window");
endmodule

// File: rtl/acq_result.sv
module acq_result
  import acq_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             adc_done_i,
  input  logic [RES_W-1:0] adc_result_i,
  input  logic             data_rd_i,
  input  logic             stat_rd_i,
  output logic [BUS_W-1:0] data_byte_o,
  output logic             sel_hi_o,
  output logic             hi_read_o,
  output logic             drdy_n_o,
  output logic             ovr_o,
  output logic             irq_o
);
  localparam int PAD_W = 2 * BUS_W - RES_W;

  logic [RES_W-1:0] res_q;
  byte_sel_e        sel_q;
  logic             drdy_n_q, ovr_q, irq_q;

  assign hi_read_o = data_rd_i && (sel_q == BYTE_HI);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      res_q    <= '0;
      sel_q    <= BYTE_LO;
      drdy_n_q <= 1'b1;
    end else if (adc_done_i) begin
      res_q    <= adc_result_i;
      sel_q    <= BYTE_LO;
      drdy_n_q <= 1'b0;
    end else if (data_rd_i) begin
      sel_q <= (sel_q == BYTE_LO) ? BYTE_HI : BYTE_LO;
      if (sel_q == BYTE_HI) drdy_n_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ovr_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= adc_done_i;
      if (adc_done_i && !drdy_n_q) ovr_q <= 1'b1;
      else if (stat_rd_i)          ovr_q <= 1'b0;
    end
  end

  assign data_byte_o = (sel_q == BYTE_LO) ? res_q[BUS_W-1:0]
                                          : {{PAD_W{1'b0}}, res_q[RES_W-1:BUS_W]};
  assign sel_hi_o = (sel_q == BYTE_HI);
  assign drdy_n_o = drdy_n_q;
  assign ovr_o    = ovr_q;
  assign irq_o    = irq_q;

  assert_flag_on_done_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    adc_done_i |=> !drdy_n_q)
    else $error("ready flag not asserted after done");

  assert_irq_with_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    irq_q |-> !drdy_n_q)
    else $error("interrupt without pending result");

  assert_flag_release_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(drdy_n_q) |-> $past(data_rd_i && sel_q == BYTE_HI))
    else $error("ready flag released without high-byte read");

  assert_ovr_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(ovr_q) |-> $past(adc_done_i && !drdy_n_q))
    else $error("overrun without lost result");
endmodule

// File: rtl/paced_acq_ctrl.sv
module paced_acq_ctrl
  import acq_pkg::*;
#(
  parameter int NCH            = 8,
  parameter int RES_W          = 12,
  parameter int BUS_W          = 8,
  parameter int TICKS_PER_CONV = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_n_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic                     bus_wr_i,
  input  logic                     bus_rd_i,
  input  logic [BUS_W-1:0]         bus_wdata_i,
  output logic [BUS_W-1:0]         bus_rdata_o,
  output logic                     tmr_wr_o,
  output logic [1:0]               tmr_sel_o,
  output logic [BUS_W-1:0]         tmr_wdata_o,
  output logic                     pacer_run_o,
  input  logic                     pacer_tick_i,
  output logic                     adc_start_o,
  output logic [$clog2(NCH)-1:0]   adc_chan_o,
  input  logic                     adc_done_i,
  input  logic [RES_W-1:0]         adc_result_i,
  output logic                     drdy_n_o,
  output logic                     irq_o
);
  localparam int CH_W = $clog2(NCH);

  logic [CH_W-1:0]  ch, fcr_new_ch;
  logic             pen, scan, trig, fcr_wr, start_wr, data_rd, stat_rd;
  logic             hi_read, sel_hi, ovr;
  logic [BUS_W-1:0] data_byte;

  acq_hostif #(.BUS_W(BUS_W), .CH_W(CH_W)) u_hostif (
    .clk_i, .rst_n_i,
    .addr_i(bus_addr_i), .wr_i(bus_wr_i), .rd_i(bus_rd_i), .wdata_i(bus_wdata_i),
    .ch_o(ch), .pen_o(pen), .scan_o(scan), .trig_o(trig),
    .fcr_wr_o(fcr_wr), .fcr_new_ch_o(fcr_new_ch), .start_wr_o(start_wr),
    .data_rd_o(data_rd), .stat_rd_o(stat_rd),
    .tmr_wr_o, .tmr_sel_o, .tmr_wdata_o
  );

  acq_sequencer #(.CH_W(CH_W), .TPC(TICKS_PER_CONV)) u_seq (
    .clk_i, .rst_n_i,
    .pen_i(pen), .scan_i(scan), .trig_i(trig), .ch_i(ch),
    .fcr_wr_i(fcr_wr), .fcr_new_ch_i(fcr_new_ch), .start_wr_i(start_wr),
    .tick_i(pacer_tick_i), .hi_read_i(hi_read), .adc_done_i,
    .adc_start_o, .adc_chan_o
  );

  acq_result #(.RES_W(RES_W), .BUS_W(BUS_W)) u_res (
    .clk_i, .rst_n_i,
    .adc_done_i, .adc_result_i,
    .data_rd_i(data_rd), .stat_rd_i(stat_rd),
    .data_byte_o(data_byte), .sel_hi_o(sel_hi), .hi_read_o(hi_read),
    .drdy_n_o, .ovr_o(ovr), .irq_o
  );

  assign pacer_run_o = pen;

  always_comb begin
    case (bus_addr_i)
      OFS_DATA: bus_rdata_o = data_byte;
      OFS_STAT: bus_rdata_o = {{(BUS_W-2){1'b0}}, ovr, drdy_n_o};
      default:  bus_rdata_o = '0;
    endcase
  end

  assert_hi_nibble_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (bus_addr_i == OFS_DATA && sel_hi) |-> (bus_rdata_o[BUS_W-1:RES_W-BUS_W] == '0))
    else $error("high byte upper bits not zero");
endmodule

// File: tb/paced_acq_ctrl_bench.sv
`timescale 1ns/1ps
module paced_acq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        tmr_wr, pacer_run;
  logic [1:0]  tmr_sel;
  logic [7:0]  tmr_wdata;
  logic        pacer_tick = 1'b0;
  logic        adc_start;
  logic [2:0]  adc_chan;
  logic        adc_done;
  logic [11:0] adc_result;
  logic        drdy_n, irq;

  always #2 clk = ~clk;

  paced_acq_ctrl u_paced_acq_ctrl (
    .clk_i(clk), .rst_n_i(rst_n),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tmr_wr_o(tmr_wr), .tmr_sel_o(tmr_sel), .tmr_wdata_o(tmr_wdata),
    .pacer_run_o(pacer_run), .pacer_tick_i(pacer_tick),
    .adc_start_o(adc_start), .adc_chan_o(adc_chan),
    .adc_done_i(adc_done), .adc_result_i(adc_result),
    .drdy_n_o(drdy_n), .irq_o(irq)
  );

  // converter model: result = {channel, 1, sequence}
  int          adc_lat = 4;
  int          lat_cnt = 0;
  logic [2:0]  pend_chan = '0;
  logic [7:0]  seq = 8'h30;
  logic [11:0] last_res = '0;
  int          start_tot = 0, irq_tot = 0, tmr_tot = 0;
  logic [2:0]  last_chan = '0;
  logic [1:0]  last_tsel = '0;
  logic [7:0]  last_tdat = '0;

  always @(posedge clk) begin
    adc_done <= 1'b0;
    if (adc_start) begin
      lat_cnt   = adc_lat;
      pend_chan = adc_chan;
      start_tot = start_tot + 1;
      last_chan = adc_chan;
    end else if (lat_cnt != 0) begin
      lat_cnt = lat_cnt - 1;
      if (lat_cnt == 0) begin
        adc_done   <= 1'b1;
        adc_result <= {pend_chan, 1'b1, seq};
        last_res    = {pend_chan, 1'b1, seq};
        seq         = seq + 8'd1;
      end
    end
    if (irq) irq_tot = irq_tot + 1;
    if (tmr_wr) begin
      tmr_tot   = tmr_tot + 1;
      last_tsel = tmr_sel;
      last_tdat = tmr_wdata;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk) pacer_tick = 1'b1;
      @(negedge clk) pacer_tick = 1'b0;
    end
  endtask

  task automatic drain();
    logic [7:0] d;
    bus_read(3'd6, d);
    bus_read(3'd6, d);
    bus_read(3'd7, d);
  endtask

  // {fcr, ticks, expected starts, expected channel}
  localparam logic [31:0] VEC [7] = '{
    {8'h13, 8'd8,  8'd1, 8'd3},  // R4 pacer mode, channel 3
    {8'h15, 8'd7,  8'd0, 8'd0},  // R4 seven ticks start nothing
    {8'h16, 8'd16, 8'd2, 8'd6},  // R4 two conversions
    {8'h07, 8'd16, 8'd0, 8'd0},  // R2 pacer disabled
    {8'h51, 8'd16, 8'd0, 8'd0},  // R5 software mode without start write
    {8'h1A, 8'd8,  8'd1, 8'd2},  // R1 bit 3 ignored
    {8'h92, 8'd8,  8'd1, 8'd2}   // R1 bit 7 ignored
  };

  initial begin
    logic [7:0] d;
    int s0, i0, t0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R12 reset state
    check(drdy_n == 1'b1, "R12", drdy_n, 1);
    check(irq == 1'b0 && adc_start == 1'b0, "R12", {irq, adc_start}, 0);
    bus_read(3'd7, d);
    check(d == 8'h01, "R12", d, 8'h01);

    // table walk
    foreach (VEC[k]) begin
      logic [7:0] f, nt, es, ec;
      string req;
      {f, nt, es, ec} = VEC[k];
      req = !f[4] ? "R2" : (f[6] ? "R5" : "R4");
      bus_write(3'd4, f);
      s0 = start_tot;
      ticks(int'(nt));
      cyc(12);
      check(start_tot - s0 == int'(es), req, start_tot - s0, es);
      if (es != 0) check(last_chan == ec[2:0], "R3", last_chan, ec);
      drain();
    end

    // R2 timer load path
    bus_write(3'd4, 8'h00);
    t0 = tmr_tot;
    bus_write(3'd1, 8'hAA);
    check(tmr_tot == t0, "R2", tmr_tot - t0, 0);
    s0 = start_tot;
    bus_write(3'd4, 8'h40);
    bus_write(3'd5, 8'h00);
    ticks(16); cyc(12);
    check(start_tot == s0, "R2", start_tot - s0, 0);
    bus_write(3'd4, 8'h10);
    check(pacer_run == 1'b1, "R2", pacer_run, 1);
    t0 = tmr_tot;
    bus_write(3'd2, 8'h5C);
    check(tmr_tot - t0 == 1 && last_tsel == 2'd2 && last_tdat == 8'h5C, "R2",
          {last_tsel, last_tdat}, {2'd2, 8'h5C});

    // R7 R8 R9 result path
    bus_write(3'd4, 8'h15);
    i0 = irq_tot;
    ticks(8); cyc(12);
    check(drdy_n == 1'b0, "R7", drdy_n, 0);
    check(irq_tot - i0 == 1, "R7", irq_tot - i0, 1);
    bus_read(3'd7, d);
    check(d == 8'h00, "R7", d, 0);
    bus_read(3'd6, d);
    check(d == last_res[7:0], "R8", d, last_res[7:0]);
    check(drdy_n == 1'b0, "R9", drdy_n, 0);
    bus_read(3'd6, d);
    check(d == {4'h0, last_res[11:8]}, "R8", d, {4'h0, last_res[11:8]});
    check(drdy_n == 1'b1, "R9", drdy_n, 1);

    // R6 eighth tick during a long conversion
    adc_lat = 40;
    bus_write(3'd4, 8'h11);
    s0 = start_tot;
    ticks(16); cyc(50);
    check(start_tot - s0 == 1, "R6", start_tot - s0, 1);
    drain();
    adc_lat = 4;

    // R5 software window
    bus_write(3'd4, 8'h54);
    s0 = start_tot;
    bus_write(3'd5, 8'h00);
    ticks(7); cyc(4);
    check(start_tot == s0, "R5", start_tot - s0, 0);
    ticks(1); cyc(4);
    check(start_tot - s0 == 1 && last_chan == 3'd4, "R5", last_chan, 4);
    ticks(8); cyc(12);
    check(start_tot - s0 == 1, "R5", start_tot - s0, 1);
    drain();

    // R10 scan sequencing with wrap
    bus_write(3'd4, 8'h36);
    ticks(8); cyc(12);
    check(last_chan == 3'd6, "R10", last_chan, 6);
    drain();
    ticks(8); cyc(12);
    check(last_chan == 3'd7, "R10", last_chan, 7);
    drain();
    ticks(8); cyc(12);
    check(last_chan == 3'd0, "R10", last_chan, 0);
    drain();

    // R11 overrun, overwrite, and R8 byte order restart
    bus_write(3'd4, 8'h10);
    ticks(8); cyc(12);
    bus_read(3'd6, d);
    ticks(8); cyc(12);
    bus_read(3'd7, d);
    check(d == 8'h02, "R11", d, 8'h02);
    bus_read(3'd7, d);
    check(d == 8'h00, "R11", d, 8'h00);
    bus_read(3'd6, d);
    check(d == last_res[7:0], "R8", d, last_res[7:0]);
    bus_read(3'd6, d);
    check(d == {4'h0, last_res[11:8]}, "R11", d, {4'h0, last_res[11:8]});
    check(drdy_n == 1'b1, "R9", drdy_n, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule